// File: doc/BRIEF.md
# Beacon Event Timer and Synchronization Counter

This block keeps a free-running 64-bit time counter in microseconds and four 16-bit beacon event timers. The counter advances by one on every microsecond tick enable. Its time-unit view (1 TU = 1024 us) is taken from bits [25:10]. Its eighth-TU view (128 us) is taken from bits [22:7]. Two of the timers count in whole TU: the next-beacon target and the end of the announcement window. The other two count in eighth-TU: the DMA alert and the software alert. When the matching view of the counter equals a timer and beaconing is enabled, that timer raises a one-cycle event. On the next edge the timer moves forward by the beacon period, which is scaled by 8 for the eighth-TU timers. A timer advances only on an exact match. If the counter is written to a time past a timer, that timer stays stale until the 16-bit view wraps round to it again.

Software reaches the block through a register-style write port and a read port with one cycle of latency. Register addresses: 0 is the counter's low 32 bits. 1 is the counter's high 32 bits. 2 to 5 are timers 0 to 3, held in the low 16 bits. 6 is control: period in bits [15:0], enable in bit 16, reset toggle in bit 17. Writing 1 to bit 17 flips an internal reset flag. When the flag goes from 0 to 1, the counter clears. Two such writes therefore return the flag to 0 without a second clear. Reading the low half of the counter captures the high half into a shadow register, so a 64-bit value read as low then high is consistent.

Two combinational flags report whether the programmed timer spacing is sane. Each accepts the four spacings that can arise with wrap-around and a partly advanced pair.

Top module: `bcn_tsf_unit`

## Requirements
- R1: After reset the counter, all timers, the period, the enable, the reset flag and the shadow are zero. Each cycle with `us_tick` high and no write to the counter raises the counter by one.
- R2: A write to address 0 replaces counter bits [31:0], and a write to address 1 replaces bits [63:32]. Such a write takes priority over a tick in the same cycle.
- R3: Timers 0 and 3 compare against counter bits [25:10]. Timers 1 and 2 compare against bits [22:7]. On a match while enabled, bit i of `bcn_evt` is high for exactly one cycle. On the next edge the timer becomes its value plus the period (plus 8 times the period for timers 1 and 2), modulo 2^16.
- R4: While the enable bit (control bit 16) is 0, `bcn_evt` stays zero and the timers keep their values even when they match.
- R5: A counter write that jumps past a timer leaves that timer unchanged. The timer fires later when the counter is placed exactly on its value.
- R6: A control write with bit 17 set flips the reset flag, which reads back in control bit 17. A flip from 0 to 1 clears all 64 counter bits. A flip from 1 to 0 leaves the counter running.
- R7: A read returns data and `rd_valid` one cycle after `rd_en`. A read of address 0 copies counter bits [63:32] into the shadow. A read of address 1 returns the shadow, not the live high half.
- R8: `atim_win_ok` is 1 exactly when one of four conditions holds, with a = timer 0, b = timer 3, w = 1 and p = period: b-a = w; a-b = p-w; (a+65536)-b = p-w; or (b+65536)-a = w.
- R9: `dma_win_ok` applies the same four conditions with a = timer 1 shifted right by 3, b = timer 0 and w = the DMA lead parameter (default 2).
- R10: Addresses 2 to 6 read back the timers and the control fields, zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-microsecond tick enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Read address |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 32 | Read data |
| bcn_evt | output | 4 | One-cycle match events, bit i for timer i |
| atim_win_ok | output | 1 | Spacing check of timer 0 against timer 3 |
| dma_win_ok | output | 1 | Spacing check of timer 1 (in TU) against timer 0 |

## Verification
Writes and ticks take effect at the edge that samples them. An event is therefore visible at the falling edge right after the write or tick that lands the counter on a timer. It is gone one cycle later, once the timer has advanced. The window flags follow the timer registers in the same cycle. Read data arrives one edge after the strobe. The driver pushes each expected read value into a queue when it issues the read, and a monitor pops and compares on every `rd_valid` seen at a falling edge. Event and window checks are taken directly at the falling edge that follows the stimulus.

// File: rtl/bcn_pkg.sv
package bcn_pkg;
   localparam int ADDR_W = 3;
   localparam int DATA_W = 32;
   localparam logic [ADDR_W-1:0] ADR_TSF_LO = 3'd0;
   localparam logic [ADDR_W-1:0] ADR_TSF_HI = 3'd1;
   localparam int                TMR_BASE   = 2;
   localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd6;
   localparam int                CTRL_EN_BIT  = 16;
   localparam int                CTRL_TGL_BIT = 17;
   localparam int                N_TIMERS     = 4;
endpackage

// File: rtl/bcn_tsf_counter.sv
module bcn_tsf_counter #(
   parameter int TSF_W  = 64,
   parameter int HALF_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [HALF_W-1:0] wr_data,
   input  logic              clr,
   output logic [TSF_W-1:0]  tsf
);
   if (TSF_W != 2*HALF_W) begin : g_bad_width
      $error("counter must be two halves wide");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tsf <= '0;
      end else if (wr_lo) begin
         tsf[HALF_W-1:0] <= wr_data;
      end else if (wr_hi) begin
         tsf[TSF_W-1:HALF_W] <= wr_data;
      end else if (clr) begin
         tsf <= '0;
      end else if (tick) begin
         tsf <= tsf + 1'b1;
      end
   end

   assert_tick_inc_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_lo && !wr_hi && !clr) |=> (tsf == $past(tsf) + 1'b1));

   assert_lo_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> (tsf[HALF_W-1:0] == $past(wr_data)));

   assert_hi_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hi |=> (tsf[TSF_W-1:HALF_W] == $past(wr_data)));
endmodule

// File: rtl/bcn_event_timer.sv
module bcn_event_timer #(
   parameter int TW        = 16,
   parameter bit SCALED    = 1'b0,
   parameter int FRAC_LOG2 = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [TW-1:0] cmp_val,
   input  logic [TW-1:0] period,
   input  logic          wr,
   input  logic [TW-1:0] wr_data,
   output logic [TW-1:0] value,
   output logic          evt
);
   logic [TW-1:0] step;

   if (SCALED) begin : g_frac_step
      assign step = period << FRAC_LOG2;
   end else begin : g_unit_step
      assign step = period;
   end

   assign evt = en && (cmp_val == value);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         value <= '0;
      end else if (wr) begin
         value <= wr_data;
      end else if (evt) begin
         value <= value + step;
      end
   end

   assert_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && !wr) |=> (value == $past(value) + $past(step)));

   assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !wr) |=> (value == $past(value)));
endmodule

// File: rtl/bcn_win_check.sv
module bcn_win_check #(
   parameter int TW = 16
) (
   input  logic [TW-1:0] a,
   input  logic [TW-1:0] b,
   input  logic [TW-1:0] window,
   input  logic [TW-1:0] intval,
   output logic          ok
);
   localparam int XW = TW + 2;
   localparam logic [XW-1:0] WRAP = XW'(1) << TW;

   logic [XW-1:0] ax, bx, wx, slack;
   logic          c_fwd, c_late, c_late_wrap, c_fwd_wrap;

   always_comb begin
      ax          = XW'(a);
      bx          = XW'(b);
      wx          = XW'(window);
      slack       = XW'(intval) - wx;
      c_fwd       = (bx - ax) == wx;
      c_late      = (ax - bx) == slack;
      c_late_wrap = ((ax | WRAP) - bx) == slack;
      c_fwd_wrap  = ((bx | WRAP) - ax) == wx;
      ok          = c_fwd || c_late || c_late_wrap || c_fwd_wrap;
   end
endmodule

// File: rtl/bcn_tsf_unit.sv
module bcn_tsf_unit
   import bcn_pkg::*;
#(
   parameter int TSF_W     = 64,
   parameter int TIMER_W   = 16,
   parameter int TU_LOG2   = 10,
   parameter int FRAC_LOG2 = 3,
   parameter int DMA_LEAD  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              us_tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [N_TIMERS-1:0] bcn_evt,
   output logic              atim_win_ok,
   output logic              dma_win_ok
);
   localparam int HALF_W     = TSF_W / 2;
   localparam int TU_SHIFT   = TU_LOG2;
   localparam int FRAC_SHIFT = TU_LOG2 - FRAC_LOG2;
   localparam int PAD_W      = DATA_W - TIMER_W;

   if (TIMER_W > 16 || TIMER_W < 8) begin : g_bad_tw
      $error("timer width out of range");
   end
   if (HALF_W != DATA_W) begin : g_bad_half
      $error("counter half must match the data width");
   end
   if (TU_SHIFT + TIMER_W > TSF_W || FRAC_SHIFT < 0) begin : g_bad_shift
      $error("time-unit slice outside the counter");
   end

   logic [TSF_W-1:0]   tsf;
   logic [HALF_W-1:0]  hi_shadow;
   logic [TIMER_W-1:0] period_q;
   logic               en_q;
   logic               tgl_q;
   logic               wr_ctrl, tsf_clr;
   logic [TIMER_W-1:0] tmr_val [N_TIMERS];
   logic [TIMER_W-1:0] tu_view, frac_view;

   assign wr_ctrl   = wr_en && (wr_addr == ADR_CTRL);
   assign tsf_clr   = wr_ctrl && wr_data[CTRL_TGL_BIT] && !tgl_q;
   assign tu_view   = tsf[TU_SHIFT +: TIMER_W];
   assign frac_view = tsf[FRAC_SHIFT +: TIMER_W];

   bcn_tsf_counter #(.TSF_W(TSF_W), .HALF_W(HALF_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (us_tick),
      .wr_lo   (wr_en && (wr_addr == ADR_TSF_LO)),
      .wr_hi   (wr_en && (wr_addr == ADR_TSF_HI)),
      .wr_data (wr_data),
      .clr     (tsf_clr),
      .tsf     (tsf)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         period_q <= '0;
         en_q     <= 1'b0;
         tgl_q    <= 1'b0;
      end else if (wr_ctrl) begin
         period_q <= wr_data[TIMER_W-1:0];
         en_q     <= wr_data[CTRL_EN_BIT];
         if (wr_data[CTRL_TGL_BIT]) tgl_q <= ~tgl_q;
      end
   end

   for (genvar i = 0; i < N_TIMERS; i++) begin : g_tmr
      localparam bit            IS_FRAC = (i == 1) || (i == 2);
      localparam logic [ADDR_W-1:0] MY_ADR = ADDR_W'(TMR_BASE + i);
      logic [TIMER_W-1:0] cmp;
      if (IS_FRAC) begin : g_frac
         assign cmp = frac_view;
      end else begin : g_unit
         assign cmp = tu_view;
      end
      bcn_event_timer #(.TW(TIMER_W), .SCALED(IS_FRAC), .FRAC_LOG2(FRAC_LOG2)) u_tmr (
         .clk     (clk),
         .rst_n   (rst_n),
         .en      (en_q),
         .cmp_val (cmp),
         .period  (period_q),
         .wr      (wr_en && (wr_addr == MY_ADR)),
         .wr_data (wr_data[TIMER_W-1:0]),
         .value   (tmr_val[i]),
         .evt     (bcn_evt[i])
      );
   end

   bcn_win_check #(.TW(TIMER_W)) u_atim_chk (
      .a      (tmr_val[0]),
      .b      (tmr_val[3]),
      .window (TIMER_W'(1)),
      .intval (period_q),
      .ok     (atim_win_ok)
   );

   bcn_win_check #(.TW(TIMER_W)) u_dma_chk (
      .a      (tmr_val[1] >> FRAC_LOG2),
      .b      (tmr_val[0]),
      .window (TIMER_W'(DMA_LEAD)),
      .intval (period_q),
      .ok     (dma_win_ok)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid  <= 1'b0;
         rd_data   <= '0;
         hi_shadow <= '0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) begin
            case (rd_addr)
               ADR_TSF_LO: begin
                  rd_data   <= tsf[HALF_W-1:0];
                  hi_shadow <= tsf[TSF_W-1:HALF_W];
               end
               ADR_TSF_HI: rd_data <= hi_shadow;
               3'd2:       rd_data <= {{PAD_W{1'b0}}, tmr_val[0]};
               3'd3:       rd_data <= {{PAD_W{1'b0}}, tmr_val[1]};
               3'd4:       rd_data <= {{PAD_W{1'b0}}, tmr_val[2]};
               3'd5:       rd_data <= {{PAD_W{1'b0}}, tmr_val[3]};
               ADR_CTRL: begin
                  rd_data <= '0;
                  rd_data[TIMER_W-1:0]  <= period_q;
                  rd_data[CTRL_EN_BIT]  <= en_q;
                  rd_data[CTRL_TGL_BIT] <= tgl_q;
               end
               default:    rd_data <= '0;
            endcase
         end
      end
   end

   assert_evt_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (|bcn_evt) |-> en_q);

   assert_evt_onehot_time_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bcn_evt[0] && period_q != '0 && !wr_en) |=> !bcn_evt[0]);

   assert_flag_flips_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && wr_data[CTRL_TGL_BIT]) |=> (tgl_q != $past(tgl_q)));

   assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tsf_clr |=> (tsf == '0));

   assert_shadow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == ADR_TSF_LO) |=> (hi_shadow == $past(tsf[TSF_W-1:HALF_W])));

   assert_read_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);

   assert_atim_adjacent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_val[3] == tmr_val[0] + 1'b1) |-> atim_win_ok);
endmodule

// File: tb/tb_bcn_tsf_unit.sv
module tb_bcn_tsf_unit;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        us_tick = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [2:0]  rd_addr = '0;
   logic        rd_valid;
   logic [31:0] rd_data;
   logic [3:0]  bcn_evt;
   logic        atim_win_ok, dma_win_ok;

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] exp_q [$];
   string       tag_q [$];

   always #(CLK_P/2) clk = ~clk;

   bcn_tsf_unit dut (
      .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
      .bcn_evt(bcn_evt), .atim_win_ok(atim_win_ok), .dma_win_ok(dma_win_ok)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: pops the scoreboard on every returned read
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R7: unexpected read data %h expected none", rd_data);
         end else begin
            check(tag_q.pop_front(), rd_data, exp_q.pop_front());
         end
      end
   end

   task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic tk = 1'b0);
      wr_en = 1'b1; wr_addr = a; wr_data = d; us_tick = tk;
      @(negedge clk);
      wr_en = 1'b0; us_tick = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
      exp_q.push_back(exp); tag_q.push_back(tag);
      rd_en = 1'b1; rd_addr = a;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic tick(input int n);
      us_tick = 1'b1;
      repeat (n) @(negedge clk);
      us_tick = 1'b0;
   endtask

   initial begin
      #(CLK_P * 100000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 evt reset", {28'b0, bcn_evt}, 32'h0);
      rd(3'd0, 32'h0, "R1 tsf lo reset");
      rd(3'd1, 32'h0, "R1 shadow reset");
      rd(3'd6, 32'h0, "R1 ctrl reset");
      rd(3'd2, 32'h0, "R1 timer0 reset");
      // R1 counting
      tick(5);
      rd(3'd0, 32'd5, "R1 five ticks");
      // R2 loads and carry into upper half
      wr(3'd0, 32'hFFFF_FFFE);
      wr(3'd1, 32'h1);
      tick(3);
      rd(3'd0, 32'h1, "R2 low after carry");
      rd(3'd1, 32'h2, "R7 shadow after carry");
      wr(3'd0, 32'd100, 1'b1);
      rd(3'd0, 32'd100, "R2 write beats tick");
      // R7 shadow holds until next low read
      wr(3'd1, 32'h7);
      rd(3'd1, 32'h2, "R7 stale shadow");
      rd(3'd0, 32'd100, "R7 low read");
      rd(3'd1, 32'h7, "R7 fresh shadow");
      // R6 reset toggle
      wr(3'd0, 32'd500);
      wr(3'd6, 32'h0002_0000);
      rd(3'd0, 32'h0, "R6 low cleared");
      rd(3'd1, 32'h0, "R6 high cleared");
      rd(3'd6, 32'h0002_0000, "R6 flag set");
      tick(4);
      wr(3'd6, 32'h0002_0000);
      rd(3'd0, 32'd4, "R6 second write no clear");
      rd(3'd6, 32'h0, "R6 flag back");
      // timer setup
      wr(3'd0, 32'h0);
      wr(3'd1, 32'h0);
      wr(3'd2, 32'd3);
      wr(3'd3, 32'd8);
      wr(3'd4, 32'd20);
      wr(3'd5, 32'd4);
      wr(3'd6, 32'h0001_000A);
      rd(3'd6, 32'h0001_000A, "R10 ctrl readback");
      check("R8 atim ok", {31'b0, atim_win_ok}, 32'h1);
      check("R9 dma ok", {31'b0, dma_win_ok}, 32'h1);
      wr(3'd5, 32'd5);
      check("R8 atim bad", {31'b0, atim_win_ok}, 32'h0);
      wr(3'd5, 32'd4);
      // R3 eighth-TU timer 1
      wr(3'd0, 32'd1023);
      check("R3 no early evt", {28'b0, bcn_evt}, 32'h0);
      tick(1);
      check("R3 timer1 evt", {28'b0, bcn_evt}, 32'h2);
      @(negedge clk);
      check("R3 timer1 pulse ends", {28'b0, bcn_evt}, 32'h0);
      rd(3'd3, 32'd88, "R3 timer1 advanced");
      // R3 timer 0 via jump; also passes timer 2
      wr(3'd0, 32'd3072);
      check("R3 timer0 evt", {28'b0, bcn_evt}, 32'h1);
      @(negedge clk);
      check("R3 timer0 pulse ends", {28'b0, bcn_evt}, 32'h0);
      rd(3'd2, 32'd13, "R3 timer0 advanced");
      wr(3'd0, 32'd4096);
      check("R3 timer3 evt", {28'b0, bcn_evt}, 32'h8);
      @(negedge clk);
      rd(3'd5, 32'd14, "R3 timer3 advanced");
      rd(3'd4, 32'd20, "R5 timer2 stale");
      wr(3'd0, 32'd2560);
      check("R5 timer2 late evt", {28'b0, bcn_evt}, 32'h4);
      @(negedge clk);
      rd(3'd4, 32'd100, "R5 timer2 advanced");
      check("R8 atim after advance", {31'b0, atim_win_ok}, 32'h1);
      check("R9 dma after advance", {31'b0, dma_win_ok}, 32'h1);
      // R4 disabled
      wr(3'd6, 32'h0000_000A);
      wr(3'd0, 32'd13312);
      check("R4 no evt disabled", {28'b0, bcn_evt}, 32'h0);
      @(negedge clk);
      check("R4 still none", {28'b0, bcn_evt}, 32'h0);
      rd(3'd2, 32'd13, "R4 timer0 held");
      // R8 wrap cases
      wr(3'd2, 32'd2);
      wr(3'd5, 32'd65529);
      check("R8 late wrap ok", {31'b0, atim_win_ok}, 32'h1);
      wr(3'd5, 32'd65530);
      check("R8 wrap off by one", {31'b0, atim_win_ok}, 32'h0);
      wr(3'd2, 32'hFFFF);
      wr(3'd5, 32'h0);
      check("R8 forward wrap ok", {31'b0, atim_win_ok}, 32'h1);
      // R9 wrong lead
      wr(3'd3, 32'h0000_FFF8);
      check("R9 dma bad lead", {31'b0, dma_win_ok}, 32'h0);
      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_chk++; n_fail++;
         $display("FAIL R7: actual %0d reads missing expected 0", exp_q.size());
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule